// File: doc/BRIEF.md
# Reloadable 16-bit Down-Counting Timer

This block is a periodic timer. A 16-bit counter steps down by one on each tick of a chosen count source, but only while the run bit is set. When a tick arrives and the counter already reads zero, the counter does not wrap. It reloads from a separate reload register, and a one-cycle interrupt request pulse is raised. A programmed value n therefore gives one interrupt every n+1 ticks.

Software controls the block through plain strobe-and-data pins:
- one strobe writes the timer value;
- one strobe writes the run bit;
- one strobe writes the 3-bit source select.

The live count is always visible on a read port. The eight count sources are single-cycle enable strobes from clock dividers and oscillators outside the block. They are synchronous to the block clock.

None of the pins carries streamed data, so there is no valid/ready handshake and no back-pressure. Every write strobe is accepted in the cycle it is high. All register updates appear on the outputs one clock after the edge that samples them.

Top module: `reload_dn_timer`

## Requirements
- R1: After reset, the count reads 0000h, the run bit is 0, the source select is 0 and the interrupt output is low. The reload register also resets to 0000h.
- R2: While running, each tick of the selected source lowers a nonzero count by exactly one.
- R3: A selected tick while running with the count at 0000h loads the reload value into the counter. In the same step the interrupt output goes high for exactly one clock. The interrupt output is high at no other time.
- R4: With programmed value n and a tick every clock, interrupts occur every n+1 ticks.
- R5: While the run bit is 0, the count holds its value and no interrupt is raised, whatever the source strobes do.
- R6: A timer write while stopped loads the written value into both the counter and the reload register.
- R7: A timer write while running changes only the reload register. A tick in the same cycle still decrements the counter. The new value enters the counter at the next underflow.
- R8: Strobes on unselected source inputs have no effect on the count.
- R9: Select value k (0 to 7) chooses source input bit k. The bits are ordered: system clock /1, /2, /8, /32, /64, fast internal oscillator, slow internal oscillator, 32 kHz clock.
- R10: A timer write that coincides with an underflow while running reloads the counter from the reload value held before the write. The written value is used at the following underflow.
- R11: Writes to the run bit and the source select appear on their outputs, and govern counting, from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_wr | input | 1 | Timer value write strobe |
| tmr_wdata | input | 16 | Timer value to write |
| run_wr | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | New run bit |
| sel_wr | input | 1 | Source select write strobe |
| sel_wdata | input | 3 | New source select |
| src_tick | input | 8 | Count-source enable strobes, bit k is source k |
| count_o | output | 16 | Live counter value |
| run_o | output | 1 | Current run bit |
| sel_o | output | 3 | Current source select |
| irq_o | output | 1 | Underflow interrupt request pulse |

## Verification
The hardest case to reach from the ports is an underflow that lands in the same cycle as a timer write while running (R10). Random writes seldom meet a tick at count zero. A directed step therefore preloads zero while stopped, starts the timer with all sources quiet, and then drives the write together with a tick. Random phases keep written values small, so underflows are frequent and land next to writes, select changes and run toggles. Another directed step strobes only the unselected source bits to show that they change nothing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int NSRC   = 8;
  localparam int SEL_W  = $clog2(NSRC);
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic             run_q,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (run_wr) run_q <= run_wdata;
      if (sel_wr) sel_q <= sel_wdata;
    end
  end

  // R11
  run_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_wr |=> run_q == $past(run_wdata));
  // R11
  sel_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
  parameter int NSRC  = 8,
  parameter int SEL_W = 3
) (
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick
);
  logic [NSRC-1:0] hit;
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = src_tick[k] && (sel == SEL_W'(k));
  end
  assign tick = run && (|hit);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  logic [CNT_W-1:0] reld;
  logic             at_zero;

  assign at_zero = (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      reld <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= tick && at_zero;
      if (wr) reld <= wdata;
      if (wr && !run) cnt <= wdata;
      else if (tick) cnt <= at_zero ? reld : cnt - 1'b1;
    end
  end

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero) |=> cnt == $past(cnt) - 1'b1);
  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick) && $past(cnt) == ZERO);
  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(cnt) && !irq);
  // R6
  stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr) |=> cnt == $past(wdata));
endmodule

// File: rtl/reload_dn_timer.sv
module reload_dn_timer
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_wr,
  input  logic [CNT_W-1:0] tmr_wdata,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [NSRC-1:0]  src_tick,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             irq_o
);
  logic tick;

  tmr_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .run_wr(run_wr), .run_wdata(run_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .run_q(run_o), .sel_q(sel_o)
  );

  tmr_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .src_tick(src_tick), .sel(sel_o), .run(run_o), .tick(tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_o), .tick(tick),
    .wr(tmr_wr), .wdata(tmr_wdata), .cnt(count_o), .irq(irq_o)
  );

  // R8
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && !src_tick[sel_o]) |=> $stable(count_o) && !irq_o);
endmodule

// File: tb/reload_dn_timer_test.sv
module reload_dn_timer_test;
  localparam time CLK_PER = 10ns;
  localparam int  WDOG    = 100000;

  logic        clk = 0, rst_n = 0;
  logic        tmr_wr = 0, run_wr = 0, run_wdata = 0, sel_wr = 0;
  logic [15:0] tmr_wdata = 0;
  logic [2:0]  sel_wdata = 0;
  logic [7:0]  src_tick = 0;
  logic [15:0] count_o;
  logic        run_o, irq_o;
  logic [2:0]  sel_o;

  int checks = 0, fails = 0, cyc = 0;

  // bench model, built from the requirements
  logic [15:0] m_cnt = 0, m_rel = 0;
  logic        m_run = 0, m_irq = 0;
  logic [2:0]  m_sel = 0;

  always #(CLK_PER/2) clk = ~clk;

  reload_dn_timer uut (
    .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .run_wr(run_wr), .run_wdata(run_wdata), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .src_tick(src_tick), .count_o(count_o),
    .run_o(run_o), .sel_o(sel_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] next_cnt(logic [15:0] c, logic [15:0] r,
      logic run, logic tk, logic wr, logic [15:0] wd);
    if (wr && !run) return wd;
    if (tk) return (c == 0) ? r : c - 16'd1;
    return c;
  endfunction

  always @(posedge clk) begin
    logic tk;
    cyc <= cyc + 1;
    tk = m_run && src_tick[m_sel];
    if (!rst_n) begin
      m_cnt <= 0; m_rel <= 0; m_run <= 0; m_sel <= 0; m_irq <= 0;
    end else begin
      m_cnt <= next_cnt(m_cnt, m_rel, m_run, tk, tmr_wr, tmr_wdata);
      m_irq <= tk && (m_cnt == 0);
      if (tmr_wr) m_rel <= tmr_wdata;
      if (run_wr) m_run <= run_wdata;
      if (sel_wr) m_sel <= sel_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic cmp_model();
    chk("R2/R6/R7 count", count_o, m_cnt);
    chk("R3 irq", irq_o, m_irq);
    chk("R11 run", run_o, m_run);
    chk("R9 sel", sel_o, m_sel);
  endtask

  task automatic idle();
    tmr_wr = 0; run_wr = 0; sel_wr = 0; src_tick = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    int irqs;
    void'($urandom(32'd20240611));
    rst_n = 0; step(); step(); rst_n = 1; step();
    // R1 reset state
    chk("R1 count", count_o, 0); chk("R1 run", run_o, 0);
    chk("R1 sel", sel_o, 0); chk("R1 irq", irq_o, 0);

    // R1 reload resets to zero: run with ticks, count stays at 0 reloading 0
    run_wr = 1; run_wdata = 1; step(); idle();
    src_tick = 8'h01; step(); idle();
    chk("R1 reload zero", count_o, 0); chk("R3 irq on zero", irq_o, 1);
    step(); chk("R3 irq one cycle", irq_o, 0);

    // R6 write while stopped
    run_wr = 1; run_wdata = 0; step(); idle();
    tmr_wr = 1; tmr_wdata = 16'd3; step(); idle();
    chk("R6 load stopped", count_o, 3);

    // R4 period n+1 with a tick each clock
    run_wr = 1; run_wdata = 1; step(); idle();
    irqs = 0;
    src_tick = 8'hFF;
    for (int i = 0; i < 20; i++) begin step(); if (irq_o) irqs++; end
    idle();
    chk("R4 irq count", irqs, 5);
    chk("R4 count after 20", count_o, 3);

    // R5 stopped holds even with ticks
    src_tick = 8'h01; step(); idle();
    chk("R2 decrement", count_o, 2);
    run_wr = 1; run_wdata = 0; src_tick = 8'h01; step();
    chk("R11 tick same edge as stop", count_o, 1);
    for (int i = 0; i < 5; i++) step();
    idle();
    chk("R5 hold", count_o, 1); chk("R5 no irq", irq_o, 0);

    // R8 / R9 select 2, unselected strobes ignored
    sel_wr = 1; sel_wdata = 3'd2; run_wr = 1; run_wdata = 1; step(); idle();
    chk("R9 sel", sel_o, 2);
    src_tick = 8'hFB; step(); step(); idle();
    chk("R8 unselected ignored", count_o, 1);
    src_tick = 8'h04; step(); idle();
    chk("R9 selected bit 2", count_o, 0);

    // R7 write while running, tick same cycle still decrements
    run_wr = 1; run_wdata = 0; step(); idle();
    tmr_wr = 1; tmr_wdata = 16'd2; step(); idle();
    run_wr = 1; run_wdata = 1; step(); idle();
    tmr_wr = 1; tmr_wdata = 16'd7; src_tick = 8'h04; step(); idle();
    chk("R7 running write keeps count", count_o, 1);
    src_tick = 8'h04; step(); step(); idle();
    chk("R7 underflow uses new reload", count_o, 7);

    // R10 write coinciding with underflow
    run_wr = 1; run_wdata = 0; step(); idle();
    tmr_wr = 1; tmr_wdata = 16'd0; step(); idle();
    run_wr = 1; run_wdata = 1; step(); idle();
    tmr_wr = 1; tmr_wdata = 16'd9; src_tick = 8'h04; step(); idle();
    chk("R10 old reload used", count_o, 0); chk("R10 irq", irq_o, 1);
    src_tick = 8'h04; step(); idle();
    chk("R10 new reload next", count_o, 9);

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      tmr_wr    = ($urandom % 8) == 0;
      tmr_wdata = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 6);
      run_wr    = ($urandom % 16) == 0;
      run_wdata = ($urandom % 4) != 0;
      sel_wr    = ($urandom % 32) == 0;
      sel_wdata = 3'($urandom);
      src_tick  = 8'($urandom) | 8'($urandom);
      step();
      cmp_model();
    end
    idle(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) if (cyc > WDOG) begin
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end
endmodule